// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Logical register names fall into two regions. The low names form a fixed region, and each fixed name addresses one physical entry directly. The high names form a rotating region. In that region a base value is added to the logical offset, modulo the size of the region, to select the physical entry. A loop-closing strobe lowers the base by one. As a result, a logical name used in one iteration selects a fresh physical register in the next iteration.

The file has one write port and two combinational read ports. A scheduler can take advantage of the rotation: a value produced as rotating name rN is found under name r(N+k) after k loop-closing strobes. A fixed producer-to-consumer latency can therefore be encoded as a distance between register names. A base-load input sets the base directly, for example at loop entry. Reset clears the base and every register.

Top module: `rot_regfile`

## Requirements
- R1: After reset the base is 0 and every logical register reads as 0 on both read ports.
- R2: Logical registers 0 to 7 address physical entries 0 to 7 directly. No base value, rotate or base load changes what they read.
- R3: A logical register l in 8 to 31 addresses physical entry 8 + ((l - 8 + base) mod 24).
- R4: Each cycle with rotate_i high and base_load_i low lowers the base by one. A base of 0 becomes 23.
- R5: With base_load_i high, the base takes base_val_i (0 to 23) on the next edge. A load wins over a rotate in the same cycle.
- R6: Reads, and a write, in the same cycle as a rotate or load use the base in effect before that edge.
- R7: A value written to rotating name rN is read as name r(N+k) after k rotates, where names above 31 wrap back to 8.
- R8: A read of the physical entry being written in the same cycle returns the previously stored value. The new value is visible from the next cycle on.
- R9: The write takes effect only when wr_en_i is high. The two read ports select their entries independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd0_addr_i | input | 5 | Logical name for read port 0 |
| rd0_data_o | output | 32 | Read port 0 data (combinational) |
| rd1_addr_i | input | 5 | Logical name for read port 1 |
| rd1_data_o | output | 32 | Read port 1 data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical name for the write |
| wr_data_i | input | 32 | Write data |
| rotate_i | input | 1 | Loop-closing strobe; lowers the base by one |
| base_load_i | input | 1 | Load the base from base_val_i |
| base_val_i | input | 5 | Base value to load, 0 to 23 |

## Verification
The assertions assume that base_val_i is always below the size of the rotating region whenever base_load_i is high. Under that assumption the base stays in range and the mapping stays inside the rotating entries. They also assume that no write is attempted while reset is held. The bench loads only the values 0, 5, 17 and 23. It keeps every control input low during reset and raises each strobe for exactly one edge. The base is then inferred at the read ports: each physical entry is filled with a pattern that encodes its own index.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned DEF_NUM_REGS   = 32;
  localparam int unsigned DEF_NUM_STATIC = 8;
  localparam int unsigned DEF_DATA_W     = 32;

  // logical name that holds a rotating value one rotate later
  function automatic int unsigned rot_next_name(int unsigned name, int unsigned num_regs,
                                                int unsigned num_static);
    return (name == num_regs - 1) ? num_static : name + 1;
  endfunction
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
  parameter int unsigned ROT_SIZE = 24,
  localparam int unsigned BW = $clog2(ROT_SIZE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rotate_i,
  input  logic          load_i,
  input  logic [BW-1:0] load_val_i,
  output logic [BW-1:0] base_o
);
  localparam logic [BW-1:0] TOP = BW'(ROT_SIZE - 1);

  logic [BW-1:0] base_q, base_d;

  always_comb begin
    base_d = base_q;
    if (load_i)        base_d = load_val_i;
    else if (rotate_i) base_d = (base_q == '0) ? TOP : base_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else         base_q <= base_d;
  end

  assign base_o = base_q;

  assert_base_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_q <= TOP);

  assert_rotate_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && !load_i) |=> ((base_q == TOP && $past(base_q) == '0) ||
                               (base_q + 1'b1 == $past(base_q))));

  assert_load_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_q == $past(load_val_i));
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int unsigned NUM_REGS   = 32,
  parameter int unsigned NUM_STATIC = 8,
  localparam int unsigned ROT_SIZE = NUM_REGS - NUM_STATIC,
  localparam int unsigned AW = $clog2(NUM_REGS),
  localparam int unsigned BW = $clog2(ROT_SIZE)
) (
  input  logic [AW-1:0] lreg_i,
  input  logic [BW-1:0] base_i,
  output logic [AW-1:0] preg_o
);
  localparam logic [AW:0] STATIC_W = (AW+1)'(NUM_STATIC);
  localparam logic [AW:0] ROT_W    = (AW+1)'(ROT_SIZE);

  logic [AW:0] off, sum, idx;

  assign off = {1'b0, lreg_i} - STATIC_W;
  assign sum = off + (AW+1)'(base_i);

  generate
    if ((1 << BW) == ROT_SIZE) begin : g_pow2
      assign idx = {{(AW+1-BW){1'b0}}, sum[BW-1:0]};
    end else begin : g_mod
      assign idx = (sum >= ROT_W) ? sum - ROT_W : sum;
    end
  endgenerate

  always_comb begin
    if ({1'b0, lreg_i} < STATIC_W) preg_o = lreg_i;
    else                           preg_o = AW'(idx + STATIC_W);
  end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned AW = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_RD-1:0][AW-1:0]      raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  generate
    for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               regs_q[e] <= '0;
        else if (we_i && waddr_i == AW'(e))        regs_q[e] <= wdata_i;
      end
    end
    // reads see the stored value; a same-cycle write lands at the edge
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      assign rdata_o[r] = regs_q[raddr_i[r]];
    end
  endgenerate
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int unsigned NUM_REGS   = rrf_pkg::DEF_NUM_REGS,
  parameter int unsigned NUM_STATIC = rrf_pkg::DEF_NUM_STATIC,
  parameter int unsigned DATA_W     = rrf_pkg::DEF_DATA_W,
  localparam int unsigned ROT_SIZE = NUM_REGS - NUM_STATIC,
  localparam int unsigned AW = $clog2(NUM_REGS),
  localparam int unsigned BW = $clog2(ROT_SIZE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     rd0_addr_i,
  output logic [DATA_W-1:0] rd0_data_o,
  input  logic [AW-1:0]     rd1_addr_i,
  output logic [DATA_W-1:0] rd1_data_o,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rotate_i,
  input  logic              base_load_i,
  input  logic [BW-1:0]     base_val_i
);
  localparam int unsigned NUM_MAP = 3;  // two reads, one write

  logic [BW-1:0]                   base;
  logic [NUM_MAP-1:0][AW-1:0]      laddr, paddr;
  logic [1:0][DATA_W-1:0]          rdata;
  logic [AW-1:0]                   wr_next_name;

  rrf_base_ctrl #(.ROT_SIZE(ROT_SIZE)) u_base (
    .clk_i, .rst_ni,
    .rotate_i   (rotate_i),
    .load_i     (base_load_i),
    .load_val_i (base_val_i),
    .base_o     (base)
  );

  assign laddr = {wr_addr_i, rd1_addr_i, rd0_addr_i};

  generate
    for (genvar m = 0; m < NUM_MAP; m++) begin : g_map
      rrf_map #(.NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC)) u_map (
        .lreg_i (laddr[m]),
        .base_i (base),
        .preg_o (paddr[m])
      );
    end
  endgenerate

  rrf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(2)) u_store (
    .clk_i, .rst_ni,
    .we_i    (wr_en_i),
    .waddr_i (paddr[2]),
    .wdata_i (wr_data_i),
    .raddr_i ({paddr[1], paddr[0]}),
    .rdata_o (rdata)
  );

  assign rd0_data_o = rdata[0];
  assign rd1_data_o = rdata[1];

  assign wr_next_name = AW'(rrf_pkg::rot_next_name(32'(wr_addr_i), NUM_REGS, NUM_STATIC));

  // plain write followed by a read of the same name returns the data
  assert_write_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && !rotate_i && !base_load_i) &&
     rd0_addr_i == $past(wr_addr_i)) |-> rd0_data_o == $past(wr_data_i));

  // one rotate moves a rotating value to the next logical name
  assert_rotation_shift_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && rotate_i && !base_load_i) &&
     $past({1'b0, wr_addr_i} >= (AW+1)'(NUM_STATIC)) &&
     rd1_addr_i == $past(wr_next_name)) |-> rd1_data_o == $past(wr_data_i));

  // fixed names are blind to the base
  assert_static_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(wr_en_i) && {1'b0, rd0_addr_i} < (AW+1)'(NUM_STATIC) &&
     rd0_addr_i == $past(rd0_addr_i)) |-> $stable(rd0_data_o));
endmodule

// File: tb/rot_regfile_test.sv
module rot_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam int NS = 8;
  localparam int NR = NL - NS;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd0_addr_i = '0, rd1_addr_i = '0, wr_addr_i = '0, base_val_i = '0;
  logic [31:0] rd0_data_o, rd1_data_o, wr_data_i = '0;
  logic        wr_en_i = 1'b0, rotate_i = 1'b0, base_load_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int base_m = 0;
  logic [31:0] mem_m [NL];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rot_regfile uut (.*);

  function automatic int phys(int l, int b);
    return (l < NS) ? l : NS + ((l - NS + b) % NR);
  endfunction

  function automatic logic [31:0] pat(int p);
    return 32'hC0DE_0000 + 32'(p);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; rotate_i = 1'b0; base_load_i = 1'b0;
  endtask

  task automatic rotate_m();
    base_m = (base_m == 0) ? NR - 1 : base_m - 1;
  endtask

  // full read sweep over all names on both ports
  task automatic sweep(string req);
    for (int l = 0; l < NL; l++) begin
      rd0_addr_i = 5'(l);
      rd1_addr_i = 5'(NL - 1 - l);
      #1;
      check(req, rd0_data_o, mem_m[phys(l, base_m)]);
      check(req, rd1_data_o, mem_m[phys(NL - 1 - l, base_m)]);
    end
  endtask

  task automatic write(int l, logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = 5'(l); wr_data_i = d;
    mem_m[phys(l, base_m)] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NL; p++) mem_m[p] = '0;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    sweep("R1 reset");

    // fill: base 0 maps name p to entry p
    for (int p = 0; p < NL; p++) begin
      write(p, pat(p));
      step();
    end
    sweep("R3 base0");

    // rotate past a full wrap, checking the whole map each time
    for (int k = 0; k < 30; k++) begin
      rotate_i = 1'b1;
      rotate_m();
      step();
      sweep("R4/R3/R2 rotate");
    end

    // load wins over rotate
    base_val_i = 5'd17; base_load_i = 1'b1; rotate_i = 1'b1;
    step(); base_m = 17;
    sweep("R5 load+rotate");
    foreach (mem_m[i]) ;
    base_val_i = 5'd23; base_load_i = 1'b1;
    step(); base_m = 23;
    sweep("R5 load23");
    base_val_i = 5'd0; base_load_i = 1'b1;
    step(); base_m = 0;
    sweep("R5 load0");

    // R6: write and reads during a rotate use the old base
    rd0_addr_i = 5'd12;
    #1 check("R6 read old base", rd0_data_o, mem_m[phys(12, 0)]);
    write(10, 32'hAAAA_0010);
    rotate_i = 1'b1;
    step(); rotate_m();
    rd1_addr_i = 5'd11;
    #1 check("R6 write old base", rd1_data_o, 32'hAAAA_0010);
    sweep("R6 after");

    // R7: name N read as N+k after k rotates, wrapping 31 -> 8
    base_val_i = 5'd5; base_load_i = 1'b1;
    step(); base_m = 5;
    write(28, 32'h7777_0028);
    step();
    for (int k = 1; k <= 6; k++) begin
      rotate_i = 1'b1;
      step(); rotate_m();
      rd0_addr_i = 5'((28 - NS + k) % NR + NS);
      #1 check("R7 latency shift", rd0_data_o, 32'h7777_0028);
    end
    // static name written during rotate is unaffected
    write(3, 32'h5555_0003);
    rotate_i = 1'b1;
    step(); rotate_m();
    rd0_addr_i = 5'd3;
    #1 check("R2 static under rotate", rd0_data_o, 32'h5555_0003);

    // R8: same-cycle read of written entry returns old value
    for (int l = 0; l < NL; l += 7) begin
      logic [31:0] old_v;
      old_v = mem_m[phys(l, base_m)];
      rd0_addr_i = 5'(l); rd1_addr_i = 5'(l);
      write(l, 32'hBEEF_0000 + 32'(l));
      #1;
      check("R8 old value p0", rd0_data_o, old_v);
      check("R8 old value p1", rd1_data_o, old_v);
      step();
      #1 check("R8 new value", rd0_data_o, 32'hBEEF_0000 + 32'(l));
    end

    // R9: write disabled has no effect
    wr_en_i = 1'b0; wr_addr_i = 5'd20; wr_data_i = 32'hDEAD_DEAD;
    step();
    step();
    sweep("R9 no write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule